// File: doc/BRIEF.md
# Interrupt-capable 32-pin GPIO port

This block is a general-purpose I/O port of 32 pins. It sits behind a simple 32-bit register bus. Software sets the level driven on each pin and chooses, pin by pin, whether the pin is an output. Software can also read back the synchronized level of every pad, whatever its direction.

Every pin can also be an interrupt source. A 2-bit trigger code per pin selects one of four conditions: low level, high level, rising edge or falling edge. The codes for pins 0..15 live in one configuration word and the codes for pins 16..31 in a second word. A detected condition sets a sticky status bit, which software clears by writing ones. A mask word selects the pins that may interrupt. The masked status of the lower half drives one interrupt line and the masked status of the upper half drives another.

Bus accesses are single-cycle. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational while `bus_sel` is high and `bus_wr` is low, and reads have no side effects.

Top module: `gpio_irq_port`

## Requirements
- R1: Registers sit at byte offsets 0x00 output value, 0x04 direction, 0x08 pad level, 0x0C trigger codes for pins 0..15, 0x10 trigger codes for pins 16..31, 0x14 mask and 0x18 status. Each writable one reads back what was written. Offset 0x1C, any offset with non-zero bits [1:0] and any offset at or above 0x20 read as zero and ignore writes.
- R2: `pad_oe` equals the direction register (1 = output) and `pad_out` equals the output value register, one clock after the write.
- R3: Offset 0x08 returns `pad_in` through two synchronizing flops: a change made before clock edge k is visible after edge k+1. Writes to 0x08 have no effect.
- R4: Pin p takes its trigger code from bits [2*(p mod 16)+1 : 2*(p mod 16)] of the word at 0x0C for p < 16, and of the word at 0x10 otherwise.
- R5: Code 0 (low level) and code 1 (high level) set the status bit on every clock edge where the synchronized level matches. While the level persists, a cleared bit is set again at once.
- R6: Code 2 (rising) and code 3 (falling) set the status bit once, when the synchronized level differs from its value one cycle earlier. A pad change made before edge k shows in status after edge k+2.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. Status bits never fall in any other way.
- R8: When a trigger and a clearing write hit the same status bit on the same edge, the bit ends set.
- R9: `irq_lo` is high when any of bits 15..0 of (status AND mask) is 1, and `irq_hi` does the same for bits 31..16. A mask bit of 1 enables its pin.
- R10: Reset (synchronous, active high) clears output value, direction, both trigger words, mask, status and the synchronizers. Because code 0 means low level and synchronized pads read 0, every status bit is 1 after the first edge following reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| pad_in | input | 32 | Raw pad levels, asynchronous |
| pad_out | output | 32 | Value driven onto pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for pins 0..15 |
| irq_hi | output | 1 | Interrupt for pins 16..31 |

## Verification
A corrupted trigger field or a wrong history flop makes status bits appear one cycle early or late, appear on the wrong pin, or fail to appear. A status read, or an enabled interrupt line, shows this within three cycles of the pad change. A wrong clear or set priority leaves a bit 0 that should be 1 right after the clearing write, and that write is followed by a read in the same cycle. The bench keeps a cycle-by-cycle model of every register. After each step it compares all register reads and all four output groups, so a divergence is reported on the cycle it first becomes visible.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Per-pin trigger selection; encodings are visible to software
    typedef enum logic [1:0] {
        TRIG_LVL_LOW  = 2'd0,
        TRIG_LVL_HIGH = 2'd1,
        TRIG_RISE     = 2'd2,
        TRIG_FALL     = 2'd3
    } trig_e;

    // Register slot, taken from byte offset bits [4:2]
    typedef enum logic [2:0] {
        REG_DATA   = 3'd0,
        REG_DIR    = 3'd1,
        REG_PADS   = 3'd2,
        REG_CFG_LO = 3'd3,
        REG_CFG_HI = 3'd4,
        REG_MASK   = 3'd5,
        REG_STAT   = 3'd6,
        REG_NONE   = 3'd7
    } reg_e;

    typedef struct packed {
        logic wr;
        logic rd;
        reg_e slot;
    } bus_op_t;

    function automatic reg_e word_select(input logic in_map, input logic [2:0] slot);
        if (!in_map) begin
            return REG_NONE;
        end
        return reg_e'(slot);
    endfunction

    function automatic logic trig_fires(input trig_e code, input logic now, input logic was);
        logic r;
        case (code)
            TRIG_LVL_LOW:  r = ~now;
            TRIG_LVL_HIGH: r = now;
            TRIG_RISE:     r = now & ~was;
            TRIG_FALL:     r = ~now & was;
            default:       r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level,
    output logic [W-1:0] level_d
);

    logic [W-1:0] stage [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] d_in;
        if (g == 0) begin : g_first
            assign d_in = raw;
        end else begin : g_rest
            assign d_in = stage[g-1];
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                stage[g] <= '0;
            end else begin
                stage[g] <= d_in;
            end
        end
    end

    // one extra sample of history for edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            level_d <= '0;
        end else begin
            level_d <= stage[STAGES-1];
        end
    end

    assign level = stage[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] level,
    input  logic [NPINS-1:0] level_d,
    input  logic [NPINS-1:0] cfg_lo,
    input  logic [NPINS-1:0] cfg_hi,
    output logic [NPINS-1:0] hit
);

    localparam int HALF = NPINS / 2;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        trig_e code;
        if (p < HALF) begin : g_low_word
            assign code = trig_e'(cfg_lo[2*p +: 2]);
        end else begin : g_high_word
            assign code = trig_e'(cfg_hi[2*(p-HALF) +: 2]);
        end
        assign hit[p] = trig_fires(code, level[p], level_d[p]);
    end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_level,
    input  logic [NPINS-1:0]  hit,
    output logic [NPINS-1:0]  data_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  cfg_lo_q,
    output logic [NPINS-1:0]  cfg_hi_q,
    output logic [NPINS-1:0]  mask_q,
    output logic [NPINS-1:0]  stat_q
);

    localparam int MAP_BITS = 5;

    logic            in_map;
    bus_op_t         op;
    logic [NPINS-1:0] clr_vec;

    assign in_map = ((bus_addr >> MAP_BITS) == '0) && (bus_addr[1:0] == 2'b00);

    always_comb begin
        op.wr   = bus_sel & bus_wr;
        op.rd   = bus_sel & ~bus_wr;
        op.slot = word_select(in_map, bus_addr[4:2]);
    end

    assign clr_vec = (op.wr && op.slot == REG_STAT) ? bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q   <= '0;
            dir_q    <= '0;
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            mask_q   <= '0;
        end else if (op.wr) begin
            case (op.slot)
                REG_DATA:   data_q   <= bus_wdata;
                REG_DIR:    dir_q    <= bus_wdata;
                REG_CFG_LO: cfg_lo_q <= bus_wdata;
                REG_CFG_HI: cfg_hi_q <= bus_wdata;
                REG_MASK:   mask_q   <= bus_wdata;
                default:    ;
            endcase
        end
    end

    // sticky status: detection has priority over a clearing write
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_vec) | hit;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (op.rd) begin
            case (op.slot)
                REG_DATA:   bus_rdata = data_q;
                REG_DIR:    bus_rdata = dir_q;
                REG_PADS:   bus_rdata = pad_level;
                REG_CFG_LO: bus_rdata = cfg_lo_q;
                REG_CFG_HI: bus_rdata = cfg_hi_q;
                REG_MASK:   bus_rdata = mask_q;
                REG_STAT:   bus_rdata = stat_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq_lo,
    output logic              irq_hi
);

    localparam int HALF      = NPINS / 2;
    localparam int SYNC_DEPTH = 2;

    logic [NPINS-1:0] pad_level;
    logic [NPINS-1:0] pad_level_d;
    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] data_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] cfg_lo_q;
    logic [NPINS-1:0] cfg_hi_q;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] stat_q;
    logic [NPINS-1:0] pend;

    gpio_irq_sync #(
        .W      (NPINS),
        .STAGES (SYNC_DEPTH)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .raw     (pad_in),
        .level   (pad_level),
        .level_d (pad_level_d)
    );

    gpio_irq_detect #(
        .NPINS (NPINS)
    ) u_detect (
        .level   (pad_level),
        .level_d (pad_level_d),
        .cfg_lo  (cfg_lo_q),
        .cfg_hi  (cfg_hi_q),
        .hit     (hit)
    );

    gpio_irq_regs #(
        .NPINS  (NPINS),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_level (pad_level),
        .hit       (hit),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .cfg_lo_q  (cfg_lo_q),
        .cfg_hi_q  (cfg_hi_q),
        .mask_q    (mask_q),
        .stat_q    (stat_q)
    );

    assign pad_out = data_q;
    assign pad_oe  = dir_q;
    assign pend    = stat_q & mask_q;
    assign irq_lo  = |pend[HALF-1:0];
    assign irq_hi  = |pend[NPINS-1:HALF];

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pad_in,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe,
    input logic              irq_lo,
    input logic              irq_hi,
    input logic [NPINS-1:0]  pad_level,
    input logic [NPINS-1:0]  hit,
    input logic [NPINS-1:0]  mask_q,
    input logic [NPINS-1:0]  stat_q
);

    localparam int HALF = NPINS / 2;

    logic [1:0] age;
    logic       wr_data;
    logic       wr_dir;
    logic       wr_stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    assign wr_data = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));
    assign wr_dir  = bus_sel && bus_wr && (bus_addr == ADDR_W'(4));
    assign wr_stat = bus_sel && bus_wr && (bus_addr == ADDR_W'(24));

    AST_PAD_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (pad_level == $past(pad_in, 2))); // R3

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (rst)
        wr_dir |=> (pad_oe == $past(bus_wdata))); // R2

    AST_OUT_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> (pad_out == $past(bus_wdata))); // R2

    AST_TRIGGER_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (($past(hit) & ~stat_q) == '0)); // R8

    AST_CLEAR_TAKES_EFFECT: assert property (@(posedge clk) disable iff (rst)
        wr_stat |=> ((stat_q & $past(bus_wdata) & ~$past(hit)) == '0)); // R7

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (($past(stat_q) & ~stat_q & ~($past(wr_stat) ? $past(bus_wdata) : '0)) == '0)); // R7

    AST_IRQ_LO_GATED: assert property (@(posedge clk) disable iff (rst)
        (mask_q[HALF-1:0] == '0) |-> !irq_lo); // R9

    AST_IRQ_HI_GATED: assert property (@(posedge clk) disable iff (rst)
        (mask_q[NPINS-1:HALF] == '0) |-> !irq_hi); // R9

endmodule

bind gpio_irq_port gpio_irq_port_chk #(
    .NPINS  (NPINS),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq_lo    (irq_lo),
    .irq_hi    (irq_hi),
    .pad_level (pad_level),
    .hit       (hit),
    .mask_q    (mask_q),
    .stat_q    (stat_q)
);

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb;

    localparam int WATCHDOG_NS = 4_000_000;

    logic        clk;
    logic        rst;
    logic        bus_sel;
    logic        bus_wr;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq_lo;
    logic        irq_hi;

    int n_tests = 0;
    int n_fail  = 0;

    // reference state
    logic [31:0] m_s1, m_s2, m_prev;
    logic [31:0] m_data, m_dir, m_clo, m_chi, m_mask, m_stat;

    gpio_irq_port u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq_lo    (irq_lo),
        .irq_hi    (irq_hi)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [31:0] ref_hits(input logic [31:0] lvl, input logic [31:0] prv,
                                             input logic [31:0] clo, input logic [31:0] chi);
        logic [31:0] r;
        logic [1:0]  code;
        r = '0;
        for (int p = 0; p < 32; p++) begin
            if (p < 16) code = clo[2*p +: 2];
            else        code = chi[2*(p-16) +: 2];
            case (code)
                2'd0:    r[p] = ~lvl[p];
                2'd1:    r[p] = lvl[p];
                2'd2:    r[p] = lvl[p] & ~prv[p];
                default: r[p] = ~lvl[p] & prv[p];
            endcase
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        if (a[1:0] != 2'b00) return '0;
        case (a[4:2])
            3'd0:    return m_data;
            3'd1:    return m_dir;
            3'd2:    return m_s2;
            3'd3:    return m_clo;
            3'd4:    return m_chi;
            3'd5:    return m_mask;
            3'd6:    return m_stat;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // advance one clock, updating the reference from pre-edge inputs
    task automatic step();
        logic [31:0] hits;
        logic [31:0] clr;
        hits = ref_hits(m_s2, m_prev, m_clo, m_chi);
        clr  = '0;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0;
            m_data = '0; m_dir = '0; m_clo = '0; m_chi = '0; m_mask = '0; m_stat = '0;
        end else begin
            if (bus_sel && bus_wr && bus_addr[1:0] == 2'b00) begin
                case (bus_addr[4:2])
                    3'd0: m_data = bus_wdata;
                    3'd1: m_dir  = bus_wdata;
                    3'd3: m_clo  = bus_wdata;
                    3'd4: m_chi  = bus_wdata;
                    3'd5: m_mask = bus_wdata;
                    3'd6: clr    = bus_wdata;
                    default: ;
                endcase
            end
            m_stat = (m_stat & ~clr) | hits;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pad_in;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic read_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        chk(bus_rdata === exp, tag, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic compare_all(input string tag);
        chk(pad_oe === m_dir, {tag, " R2 oe"}, pad_oe, m_dir);
        chk(pad_out === m_data, {tag, " R2 out"}, pad_out, m_data);
        chk(irq_lo === |(m_stat[15:0] & m_mask[15:0]), {tag, " R9 irq_lo"},
            32'(irq_lo), 32'(|(m_stat[15:0] & m_mask[15:0])));
        chk(irq_hi === |(m_stat[31:16] & m_mask[31:16]), {tag, " R9 irq_hi"},
            32'(irq_hi), 32'(|(m_stat[31:16] & m_mask[31:16])));
        for (int w = 0; w < 8; w++) begin
            read_chk(5'(w * 4), exp_read(5'(w * 4)), {tag, " R1 read"});
        end
    endtask

    initial begin
        #(WATCHDOG_NS);
        n_fail++;
        $display("FAIL watchdog expired before the sequence ended");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20511));
        rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
        m_s1 = '0; m_s2 = '0; m_prev = '0;
        m_data = '0; m_dir = '0; m_clo = '0; m_chi = '0; m_mask = '0; m_stat = '0;
        @(negedge clk);
        steps(3);
        rst = 1'b0;

        // R10 reset state
        chk(pad_oe === '0, "R10 oe after reset", pad_oe, 32'h0);
        chk(pad_out === '0, "R10 out after reset", pad_out, 32'h0);
        chk({irq_hi, irq_lo} === 2'b00, "R10 irq after reset", 32'({irq_hi, irq_lo}), 32'h0);
        read_chk(5'h18, 32'h0, "R10 status after reset");
        read_chk(5'h14, 32'h0, "R10 mask after reset");
        step();
        read_chk(5'h18, 32'hFFFF_FFFF, "R10 R5 default low-level fills status");

        // R1 / R2 register map
        bus_write(5'h00, 32'hA5A5_0F0F);
        bus_write(5'h04, 32'h0000_FFFF);
        read_chk(5'h00, 32'hA5A5_0F0F, "R1 data readback");
        read_chk(5'h04, 32'h0000_FFFF, "R1 dir readback");
        chk(pad_out === 32'hA5A5_0F0F, "R2 pad_out", pad_out, 32'hA5A5_0F0F);
        chk(pad_oe === 32'h0000_FFFF, "R2 pad_oe", pad_oe, 32'h0000_FFFF);
        read_chk(5'h1C, 32'h0, "R1 unmapped offset");
        read_chk(5'h01, 32'h0, "R1 misaligned offset");
        bus_write(5'h02, 32'hFFFF_FFFF);
        read_chk(5'h00, 32'hA5A5_0F0F, "R1 misaligned write ignored");

        // R3 pad level
        bus_write(5'h08, 32'hFFFF_FFFF);
        read_chk(5'h08, 32'h0, "R3 write to pad level ignored");
        pad_in = 32'h1234_5678;
        step();
        read_chk(5'h08, 32'h0, "R3 pad level not yet visible");
        step();
        read_chk(5'h08, 32'h1234_5678, "R3 pad level after two edges");
        pad_in = '0;
        steps(4);

        // R4 fields: pin3 rising, pin31 falling, rest high level
        bus_write(5'h0C, 32'h5555_5595);
        bus_write(5'h10, 32'hD555_5555);
        read_chk(5'h10, 32'hD555_5555, "R1 R4 high config readback");
        bus_write(5'h18, 32'hFFFF_FFFF);
        read_chk(5'h18, 32'h0, "R7 clear all");

        // R6 rising edge on pin 3
        pad_in = 32'h0000_0008;
        steps(2);
        read_chk(5'h18, 32'h0, "R6 rise not yet in status");
        step();
        read_chk(5'h18, 32'h0000_0008, "R6 rise after three edges");
        steps(3);
        read_chk(5'h18, 32'h0000_0008, "R6 edge sets once and sticks");
        bus_write(5'h18, 32'h0000_0008);
        read_chk(5'h18, 32'h0, "R7 write one clears");
        steps(2);
        read_chk(5'h18, 32'h0, "R6 steady high does not re-trigger edge");

        // R5 level on pin 20
        pad_in = 32'h0010_0008;
        steps(3);
        read_chk(5'h18, 32'h0010_0000, "R5 high level sets");
        bus_write(5'h18, 32'h0010_0000);
        read_chk(5'h18, 32'h0010_0000, "R5 R8 persistent level survives clear");
        bus_write(5'h18, 32'h0);
        read_chk(5'h18, 32'h0010_0000, "R7 write zero no effect");

        // R9 masking per half
        bus_write(5'h14, 32'h0010_0000);
        chk({irq_hi, irq_lo} === 2'b10, "R9 upper line only", 32'({irq_hi, irq_lo}), 32'h2);
        bus_write(5'h14, 32'h0000_0008);
        chk({irq_hi, irq_lo} === 2'b00, "R9 masked pending absent", 32'({irq_hi, irq_lo}), 32'h0);

        // R8 collision on pin 3
        pad_in = 32'h0010_0000;
        steps(3);
        pad_in = 32'h0010_0008;
        steps(2);
        bus_write(5'h18, 32'h0000_0008);
        read_chk(5'h18, 32'h0010_0008, "R8 set wins over clear");
        chk(irq_lo === 1'b1, "R9 lower line", 32'(irq_lo), 32'h1);

        // R4 falling edge on pin 31 (upper word, bits 31:30)
        pad_in = 32'h8010_0008;
        steps(4);
        bus_write(5'h18, 32'hFFFF_FFFF);
        read_chk(5'h18, 32'h0010_0000, "R4 rise ignored by falling code");
        pad_in = 32'h0010_0008;
        steps(3);
        read_chk(5'h18, 32'h8010_0000, "R4 falling on pin 31");
        bus_write(5'h14, 32'h8000_0000);
        chk(irq_hi === 1'b1, "R9 pin 31 drives upper line", 32'(irq_hi), 32'h1);
        compare_all("directed");

        // random mix against the reference
        for (int it = 0; it < 400; it++) begin
            int unsigned r;
            r = $urandom % 10;
            if (r < 4) begin
                pad_in = $urandom;
                step();
            end else if (r < 8) begin
                logic [4:0]  a;
                logic [31:0] d;
                a = 5'(($urandom % 8) * 4);
                d = $urandom;
                if (a == 5'h18) d = d & $urandom;
                bus_write(a, d);
            end else begin
                step();
            end
            compare_all("random R4 R5 R6 R7");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule